// File: doc/BRIEF.md
# Multichannel DAC Serial Register Bank

This block is the digital front end of a multichannel digital-to-analog converter. It acts as a serial peripheral (SPI, mode with data sampled on the rising clock edge). Each transfer carries one 24-bit command word, most significant bit first. From these words the block maintains three registers per channel: a code register, an offset-trim register and a gain-trim register. It also maintains a small special-function space. That space holds a control word, whose bit 0 is a global power-down flag, and one 14-bit DAC-offset register for each reference group.

Channels are grouped by a parameter. Every channel sees the DAC-offset register of its own group. Groups beyond the number of references all share the last one. Data resolution is a parameter. When it is below 16 bits, the code sits left-aligned in the 16-bit field of the command word.

A host can ask for any register to be returned. The value appears on the serial output during the transfer that follows the request. The serial pins are oversampled by the system clock, so the block runs entirely in one clock domain. Everything it holds is presented in parallel at its outputs for the analog side.

Top module: `dac_spi_regbank`

## Requirements
- R1: A transfer of exactly 24 rising SCLK edges while chip select is low forms a word. Bits 23:22 are the command, bits 21:16 the address and bits 15:0 the field. Command 3 at address 8+n loads the field into channel n's code register, which is visible on `chan_data_o` once chip select has risen.
- R2: Command 2 at address 8+n loads channel n's offset-trim register. Command 1 at address 8+n loads channel n's gain-trim register.
- R3: With resolution RES, each channel register stores field bits [15:16-RES]. On readback, a channel register returns its value shifted left by 16-RES, with zeros in the low bits.
- R4: Command 0 at address 1 writes the control word. Bit 0 of the field sets `pwr_down_o` and the other field bits have no effect.
- R5: Command 0 at address 2+g, for g below NUM_REF, loads field[13:0] into the DAC-offset register of reference g. Channel c presents on `chan_dac_ofs_o` the register of reference min(c / CH_PER_GRP, NUM_REF-1).
- R6: Command 0 at address 5 is a readback request, with the type in field[15:13] and the register address in field[12:7]. During the next 24-bit transfer, bits 15:0 of the shifted-out word carry the register and bits 23:16 are zero. The types are:
  - 0 and 1: the code register.
  - 2: the offset-trim register.
  - 3: the gain-trim register.
  - 4: a special-function register. Address 1 gives the power-down flag in bit 0, and address 2+g gives the zero-extended offset of reference g.
  - Types 5 to 7, and addresses that are not mapped, return 0.
- R7: SDO changes only after a falling SCLK edge or a falling chip select, and carries the word most significant bit first. A transfer with no readback pending shifts out all zeros. A pending readback is used up by the very next transfer, whatever its length.
- R8: A transfer with any count of rising SCLK edges other than 24 changes no register.
- R9: Writes to addresses that are not mapped change nothing. These are channel commands below address 8 or at 8+NUM_CH and above, and special-function addresses 0, 6 and up, or 2+g with g not below NUM_REF.
- R10: After reset, code and offset-trim registers are 0, gain-trim registers are all ones, DAC-offset registers are 0 and `pwr_down_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select framing a transfer |
| spi_mosi | input | 1 | Serial data from the host, sampled on rising SCLK |
| spi_sdo | output | 1 | Serial readback data, updated after falling SCLK |
| chan_data_o | output | NUM_CH*RES | Code register of every channel, channel 0 in the low bits |
| chan_ofs_o | output | NUM_CH*RES | Offset-trim register of every channel |
| chan_gain_o | output | NUM_CH*RES | Gain-trim register of every channel |
| chan_dac_ofs_o | output | NUM_CH*14 | DAC-offset register of each channel's reference group |
| pwr_down_o | output | 1 | Global power-down flag |

## Verification
The bench builds the block with 12 channels, 4 channels per group, 2 references and 14-bit resolution. The 14-bit width makes the left-alignment and the zero low bits of readback visible. The third group of channels must fold onto the second reference, which checks that groups share a register. With only two references, the third special-function offset address becomes an unmapped write. Addresses 7 and 20 fall just outside the channel window on each side.

// File: rtl/dac_rb_pkg.sv
package dac_rb_pkg;

  localparam int FRAME_BITS = 24;
  localparam int ADDR_W     = 6;
  localparam int FIELD_W    = 16;
  localparam int GOFS_W     = 14;
  localparam int CH_BASE    = 8;

  typedef enum logic [1:0] {
    CMD_SF   = 2'd0,
    CMD_GAIN = 2'd1,
    CMD_OFS  = 2'd2,
    CMD_DATA = 2'd3
  } cmd_e;

  // readback type codes
  localparam logic [2:0] RB_DATA = 3'd0;
  localparam logic [2:0] RB_ALT  = 3'd1;
  localparam logic [2:0] RB_OFS  = 3'd2;
  localparam logic [2:0] RB_GAIN = 3'd3;
  localparam logic [2:0] RB_SF   = 3'd4;

  // special-function addresses
  localparam logic [ADDR_W-1:0] SF_CTRL  = 6'd1;
  localparam logic [ADDR_W-1:0] SF_GOFS0 = 6'd2;
  localparam logic [ADDR_W-1:0] SF_RBREQ = 6'd5;

  typedef struct packed {
    cmd_e                cmd;
    logic [ADDR_W-1:0]   addr;
    logic [FIELD_W-1:0]  field;
  } frame_t;

  // channel slot addressed by a word address (valid only when chan_hit)
  function automatic logic [ADDR_W-1:0] chan_slot(input logic [ADDR_W-1:0] addr);
    return addr - ADDR_W'(CH_BASE);
  endfunction

  function automatic logic chan_hit(input logic [ADDR_W-1:0] addr, input int nch);
    return (int'(addr) >= CH_BASE) && (int'(addr) < CH_BASE + nch);
  endfunction

  // reference group of a channel; groups past the last reference fold onto it
  function automatic int ref_group(input int ch, input int cpg, input int nref);
    int g;
    g = ch / cpg;
    if (g >= nref) g = nref - 1;
    return g;
  endfunction

  // place a right-justified res-bit value at the top of a 16-bit field
  function automatic logic [FIELD_W-1:0] left_align(input logic [FIELD_W-1:0] v, input int res);
    return v << (FIELD_W - res);
  endfunction

endpackage

// File: rtl/dac_spi_frame_rx.sv
module dac_spi_frame_rx
  import dac_rb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sclk_i,
  input  logic   cs_n_i,
  input  logic   mosi_i,
  output frame_t frame_o,
  output logic   exec_o,
  output logic   sclk_fall_o,
  output logic   cs_fall_o,
  output logic   cs_high_o
);

  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

  logic [2:0] sclk_q;
  logic [2:0] cs_q;
  logic [1:0] mosi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk_i};
      cs_q   <= {cs_q[1:0], cs_n_i};
      mosi_q <= {mosi_q[0], mosi_i};
    end
  end

  logic sclk_rise, cs_rise, cs_low;
  assign sclk_rise   = sclk_q[1] & ~sclk_q[2];
  assign sclk_fall_o = ~sclk_q[1] & sclk_q[2];
  assign cs_fall_o   = ~cs_q[1] & cs_q[2];
  assign cs_rise     = cs_q[1] & ~cs_q[2];
  assign cs_low      = ~cs_q[1];
  assign cs_high_o   = cs_q[1];

  logic [FRAME_BITS-1:0] shreg_q;
  logic [CNT_W-1:0]      cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (cs_fall_o) begin
      cnt_q <= '0;
    end else if (cs_low && sclk_rise) begin
      shreg_q <= {shreg_q[FRAME_BITS-2:0], mosi_q[1]};
      if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign exec_o  = cs_rise && (cnt_q == CNT_FULL);
  assign frame_o = frame_t'(shreg_q);

endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_rb_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_REF = 2
) (
  input  frame_t               frame_i,
  input  logic                 exec_i,
  output logic                 wr_data_o,
  output logic                 wr_ofs_o,
  output logic                 wr_gain_o,
  output logic [ADDR_W-1:0]    slot_o,
  output logic [FIELD_W-1:0]   field_o,
  output logic                 wr_ctrl_o,
  output logic [NUM_REF-1:0]   wr_gofs_o,
  output logic                 rb_req_o,
  output logic [2:0]           rb_type_o,
  output logic [ADDR_W-1:0]    rb_addr_o
);

  logic hit;
  assign hit       = chan_hit(frame_i.addr, NUM_CH);
  assign slot_o    = chan_slot(frame_i.addr);
  assign field_o   = frame_i.field;
  assign rb_type_o = frame_i.field[15:13];
  assign rb_addr_o = frame_i.field[12:7];

  always_comb begin
    wr_data_o = 1'b0;
    wr_ofs_o  = 1'b0;
    wr_gain_o = 1'b0;
    wr_ctrl_o = 1'b0;
    wr_gofs_o = '0;
    rb_req_o  = 1'b0;
    if (exec_i) begin
      unique case (frame_i.cmd)
        CMD_DATA: wr_data_o = hit;
        CMD_OFS:  wr_ofs_o  = hit;
        CMD_GAIN: wr_gain_o = hit;
        CMD_SF: begin
          if (frame_i.addr == SF_CTRL)  wr_ctrl_o = 1'b1;
          if (frame_i.addr == SF_RBREQ) rb_req_o  = 1'b1;
          for (int g = 0; g < NUM_REF; g++) begin
            if (frame_i.addr == SF_GOFS0 + ADDR_W'(g)) wr_gofs_o[g] = 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/dac_chan_bank.sv
module dac_chan_bank
  import dac_rb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_data_i,
  input  logic                  wr_ofs_i,
  input  logic                  wr_gain_i,
  input  logic [ADDR_W-1:0]     slot_i,
  input  logic [FIELD_W-1:0]    field_i,
  input  logic [ADDR_W-1:0]     rd_slot_i,
  output logic [NUM_CH*RES-1:0] data_o,
  output logic [NUM_CH*RES-1:0] ofs_o,
  output logic [NUM_CH*RES-1:0] gain_o,
  output logic [FIELD_W-1:0]    rd_data_o,
  output logic [FIELD_W-1:0]    rd_ofs_o,
  output logic [FIELD_W-1:0]    rd_gain_o
);

  logic [RES-1:0] wval;
  logic           unused_field;
  assign wval         = field_i[FIELD_W-1 -: RES];
  assign unused_field = ^field_i;

  logic [RES-1:0] data_q [NUM_CH];
  logic [RES-1:0] ofs_q  [NUM_CH];
  logic [RES-1:0] gain_q [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel;
    assign sel = (slot_i == ADDR_W'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data_q[c] <= '0;
        ofs_q[c]  <= '0;
        gain_q[c] <= '1;
      end else begin
        if (wr_data_i && sel) data_q[c] <= wval;
        if (wr_ofs_i  && sel) ofs_q[c]  <= wval;
        if (wr_gain_i && sel) gain_q[c] <= wval;
      end
    end

    assign data_o[c*RES +: RES] = data_q[c];
    assign ofs_o[c*RES +: RES]  = ofs_q[c];
    assign gain_o[c*RES +: RES] = gain_q[c];
  end

  always_comb begin
    rd_data_o = '0;
    rd_ofs_o  = '0;
    rd_gain_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_slot_i == ADDR_W'(c)) begin
        rd_data_o = left_align(FIELD_W'(data_q[c]), RES);
        rd_ofs_o  = left_align(FIELD_W'(ofs_q[c]), RES);
        rd_gain_o = left_align(FIELD_W'(gain_q[c]), RES);
      end
    end
  end

endmodule

// File: rtl/dac_readback_tx.sv
module dac_readback_tx
  import dac_rb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [FIELD_W-1:0] value_i,
  input  logic               cs_fall_i,
  input  logic               sclk_fall_i,
  input  logic               cs_high_i,
  output logic               sdo_o
);

  logic                  pend_q;
  logic [FIELD_W-1:0]    pval_q;
  logic [FRAME_BITS-1:0] tx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pval_q <= '0;
      tx_q   <= '0;
    end else begin
      if (cs_fall_i) begin
        tx_q   <= pend_q ? FRAME_BITS'(pval_q) : '0;
        pend_q <= 1'b0;
      end else if (sclk_fall_i && !cs_high_i) begin
        tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
      end
      if (load_i) begin
        pend_q <= 1'b1;
        pval_q <= value_i;
      end
    end
  end

  assign sdo_o = tx_q[FRAME_BITS-1];

endmodule

// File: rtl/dac_spi_regbank.sv
module dac_spi_regbank
  import dac_rb_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int CH_PER_GRP = 4,
  parameter int NUM_REF    = 2,
  parameter int RES        = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     spi_sclk,
  input  logic                     spi_cs_n,
  input  logic                     spi_mosi,
  output logic                     spi_sdo,
  output logic [NUM_CH*RES-1:0]    chan_data_o,
  output logic [NUM_CH*RES-1:0]    chan_ofs_o,
  output logic [NUM_CH*RES-1:0]    chan_gain_o,
  output logic [NUM_CH*GOFS_W-1:0] chan_dac_ofs_o,
  output logic                     pwr_down_o
);

  // internal events, named for the bound checker
  frame_t               frame;
  logic                 frame_exec, sclk_fall, cs_fall, cs_high;
  logic                 wr_data, wr_ofs, wr_gain, wr_ctrl, rb_req;
  logic [NUM_REF-1:0]   wr_gofs;
  logic [ADDR_W-1:0]    slot, rb_addr;
  logic [FIELD_W-1:0]   field;
  logic [2:0]           rb_type;

  dac_spi_frame_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_i     (spi_sclk),
    .cs_n_i     (spi_cs_n),
    .mosi_i     (spi_mosi),
    .frame_o    (frame),
    .exec_o     (frame_exec),
    .sclk_fall_o(sclk_fall),
    .cs_fall_o  (cs_fall),
    .cs_high_o  (cs_high)
  );

  dac_cmd_decode #(.NUM_CH(NUM_CH), .NUM_REF(NUM_REF)) u_dec (
    .frame_i  (frame),
    .exec_i   (frame_exec),
    .wr_data_o(wr_data),
    .wr_ofs_o (wr_ofs),
    .wr_gain_o(wr_gain),
    .slot_o   (slot),
    .field_o  (field),
    .wr_ctrl_o(wr_ctrl),
    .wr_gofs_o(wr_gofs),
    .rb_req_o (rb_req),
    .rb_type_o(rb_type),
    .rb_addr_o(rb_addr)
  );

  logic [FIELD_W-1:0] rd_data, rd_ofs, rd_gain;

  dac_chan_bank #(.NUM_CH(NUM_CH), .RES(RES)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_data_i(wr_data),
    .wr_ofs_i (wr_ofs),
    .wr_gain_i(wr_gain),
    .slot_i   (slot),
    .field_i  (field),
    .rd_slot_i(chan_slot(rb_addr)),
    .data_o   (chan_data_o),
    .ofs_o    (chan_ofs_o),
    .gain_o   (chan_gain_o),
    .rd_data_o(rd_data),
    .rd_ofs_o (rd_ofs),
    .rd_gain_o(rd_gain)
  );

  // special-function space
  logic              pd_q;
  logic [GOFS_W-1:0] gofs_q [NUM_REF];

  always_ff @(posedge clk) begin
    if (!rst_n)       pd_q <= 1'b0;
    else if (wr_ctrl) pd_q <= field[0];
  end
  assign pwr_down_o = pd_q;

  for (genvar g = 0; g < NUM_REF; g++) begin : g_ref
    always_ff @(posedge clk) begin
      if (!rst_n)          gofs_q[g] <= '0;
      else if (wr_gofs[g]) gofs_q[g] <= field[GOFS_W-1:0];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_map
    localparam int GRP = ref_group(c, CH_PER_GRP, NUM_REF);
    assign chan_dac_ofs_o[c*GOFS_W +: GOFS_W] = gofs_q[GRP];
  end

  // readback value, captured when the request executes
  logic               rb_chan;
  logic [FIELD_W-1:0] rb_value;
  assign rb_chan = chan_hit(rb_addr, NUM_CH);

  always_comb begin
    rb_value = '0;
    case (rb_type)
      RB_DATA, RB_ALT: if (rb_chan) rb_value = rd_data;
      RB_OFS:          if (rb_chan) rb_value = rd_ofs;
      RB_GAIN:         if (rb_chan) rb_value = rd_gain;
      RB_SF: begin
        if (rb_addr == SF_CTRL) rb_value = FIELD_W'(pd_q);
        for (int g = 0; g < NUM_REF; g++) begin
          if (rb_addr == SF_GOFS0 + ADDR_W'(g)) rb_value = FIELD_W'(gofs_q[g]);
        end
      end
      default: rb_value = '0;
    endcase
  end

  dac_readback_tx u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (rb_req),
    .value_i    (rb_value),
    .cs_fall_i  (cs_fall),
    .sclk_fall_i(sclk_fall),
    .cs_high_i  (cs_high),
    .sdo_o      (spi_sdo)
  );

endmodule

// File: rtl/dac_rb_checker.sv
module dac_rb_checker #(
  parameter int DATA_W  = 8,
  parameter int NUM_REF = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_exec,
  input logic               cs_high,
  input logic               sclk_fall,
  input logic               cs_fall,
  input logic               sdo,
  input logic               pwr_down,
  input logic [DATA_W-1:0]  chan_data,
  input logic               wr_data,
  input logic               wr_ofs,
  input logic               wr_gain,
  input logic               wr_ctrl,
  input logic [NUM_REF-1:0] wr_gofs,
  input logic               rb_req
);

  // R8: a word executes only once chip select is back high
  a_r8_exec_at_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    frame_exec |-> cs_high);

  // R1: code registers move only on a decoded code write
  a_r1_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> $stable(chan_data));

  // R4: power-down changes only on a control write
  a_r4_pd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(pwr_down));

  // R7: serial output moves only after a falling SCLK or chip select
  a_r7_sdo_edges: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_fall || cs_fall) |=> $stable(sdo));

  // R2: one word performs at most one kind of action
  a_r2_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_data, wr_ofs, wr_gain, wr_ctrl, rb_req, |wr_gofs}));

  // R6: a readback request comes only from an executed word
  a_r6_req_on_exec: assert property (@(posedge clk) disable iff (!rst_n)
    rb_req |-> frame_exec);

endmodule

bind dac_spi_regbank dac_rb_checker #(
  .DATA_W (NUM_CH*RES),
  .NUM_REF(NUM_REF)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_exec(frame_exec),
  .cs_high   (cs_high),
  .sclk_fall (sclk_fall),
  .cs_fall   (cs_fall),
  .sdo       (spi_sdo),
  .pwr_down  (pwr_down_o),
  .chan_data (chan_data_o),
  .wr_data   (wr_data),
  .wr_ofs    (wr_ofs),
  .wr_gain   (wr_gain),
  .wr_ctrl   (wr_ctrl),
  .wr_gofs   (wr_gofs),
  .rb_req    (rb_req)
);

// File: tb/test_dac_spi_regbank.sv
module test_dac_spi_regbank;

  localparam int NCH  = 12;
  localparam int CPG  = 4;
  localparam int NREF = 2;
  localparam int RES  = 14;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic sdo;
  logic [NCH*RES-1:0] data_o, ofs_o, gain_o;
  logic [NCH*14-1:0]  dofs_o;
  logic               pd_o;

  always #5 clk = ~clk;

  dac_spi_regbank #(.NUM_CH(NCH), .CH_PER_GRP(CPG), .NUM_REF(NREF), .RES(RES)) i_dac_spi_regbank (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_sdo(sdo), .chan_data_o(data_o), .chan_ofs_o(ofs_o), .chan_gain_o(gain_o),
    .chan_dac_ofs_o(dofs_o), .pwr_down_o(pd_o)
  );

  int n_checks = 0;
  int n_errors = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model
  logic [RES-1:0] m_data [NCH];
  logic [RES-1:0] m_ofs  [NCH];
  logic [RES-1:0] m_gain [NCH];
  logic [13:0]    m_gofs [NREF];
  logic           m_pd;
  logic [15:0]    m_pend;
  bit             m_pend_ok;

  logic [23:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [15:0] m_read(input logic [2:0] t, input logic [5:0] a);
    int ch;
    bit hit;
    ch  = int'(a) - 8;
    hit = (ch >= 0) && (ch < NCH);
    case (t)
      3'd0, 3'd1: return hit ? {m_data[ch], 2'b00} : 16'h0;
      3'd2:       return hit ? {m_ofs[ch], 2'b00} : 16'h0;
      3'd3:       return hit ? {m_gain[ch], 2'b00} : 16'h0;
      3'd4: begin
        if (a == 6'd1) return {15'h0, m_pd};
        if (a >= 6'd2 && int'(a) < 2 + NREF) return {2'b00, m_gofs[int'(a) - 2]};
        return 16'h0;
      end
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_apply(input logic [1:0] cmd, input logic [5:0] a, input logic [15:0] f);
    int ch;
    ch = int'(a) - 8;
    if (cmd != 2'd0) begin
      if (ch >= 0 && ch < NCH) begin
        if (cmd == 2'd3) m_data[ch] = f[15:2];
        if (cmd == 2'd2) m_ofs[ch]  = f[15:2];
        if (cmd == 2'd1) m_gain[ch] = f[15:2];
      end
    end else begin
      if (a == 6'd1) m_pd = f[0];
      if (a >= 6'd2 && int'(a) < 2 + NREF) m_gofs[int'(a) - 2] = f[13:0];
      if (a == 6'd5) begin
        m_pend    = m_read(f[15:13], f[12:7]);
        m_pend_ok = 1'b1;
      end
    end
  endtask

  // driver: pushes the expected serial word, then shifts the word out
  task automatic xfer(input logic [1:0] cmd, input logic [5:0] a, input logic [15:0] f,
                      input int nbits, input string tag);
    logic [23:0] w;
    w = {cmd, a, f};
    if (nbits == 24) begin
      exp_q.push_back(m_pend_ok ? {8'h00, m_pend} : 24'h0);
      tag_q.push_back(tag);
    end
    m_pend_ok = 1'b0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 24) ? w[23-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
    if (nbits == 24) model_apply(cmd, a, f);
  endtask

  // monitor: collects SDO and compares against the scoreboard queue
  logic [23:0] mon_word = '0;
  int          mon_cnt = 0;

  always @(negedge cs_n) begin
    mon_cnt  = 0;
    mon_word = '0;
  end

  always @(posedge sclk) begin
    if (!cs_n) begin
      mon_word = {mon_word[22:0], sdo};
      mon_cnt++;
    end
  end

  always @(posedge cs_n) begin
    if (mon_cnt == 24) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected word", 32'(mon_word), 32'hFFFF_FFFF);
      end else begin
        logic [23:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 32'(mon_word), 32'(e));
      end
    end
  end

  task automatic check_outputs(input string tag);
    for (int c = 0; c < NCH; c++) begin
      int g;
      g = c / CPG;
      if (g >= NREF) g = NREF - 1;
      check({tag, " data"}, 32'(data_o[c*RES +: RES]), 32'(m_data[c]));
      check({tag, " ofs"},  32'(ofs_o[c*RES +: RES]),  32'(m_ofs[c]));
      check({tag, " gain"}, 32'(gain_o[c*RES +: RES]), 32'(m_gain[c]));
      check({tag, " dac ofs"}, 32'(dofs_o[c*14 +: 14]), 32'(m_gofs[g]));
    end
    check({tag, " pd"}, 32'(pd_o), 32'(m_pd));
  endtask

  function automatic logic [15:0] rbq(input logic [2:0] t, input logic [5:0] a);
    return {t, a, 7'h00};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_data[c] = '0;
      m_ofs[c]  = '0;
      m_gain[c] = '1;
    end
    for (int g = 0; g < NREF; g++) m_gofs[g] = '0;
    m_pd = 1'b0;
    m_pend = '0;
    m_pend_ok = 1'b0;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_outputs("R10 reset");

    // R1: code writes, MSB-first framing
    xfer(2'd3, 6'd8,  16'hABCD, 24, "R1 idle sdo");
    xfer(2'd3, 6'd19, 16'h1234, 24, "R1 idle sdo");
    xfer(2'd3, 6'd13, 16'hFFFF, 24, "R1 idle sdo");
    check_outputs("R1");
    check("R3 stored top bits", 32'(data_o[0 +: RES]), 32'h2AF3);

    // R2: trim writes
    xfer(2'd2, 6'd11, 16'h5555, 24, "R2 idle sdo");
    xfer(2'd1, 6'd15, 16'h8001, 24, "R2 idle sdo");
    check_outputs("R2");

    // R4: control word
    xfer(2'd0, 6'd1, 16'h0001, 24, "R4 idle sdo");
    check_outputs("R4 set");
    xfer(2'd0, 6'd1, 16'hFFFE, 24, "R4 idle sdo");
    check_outputs("R4 clear");

    // R5: group offsets and folding of the third group
    xfer(2'd0, 6'd2, 16'hF123, 24, "R5 idle sdo");
    xfer(2'd0, 6'd3, 16'h0456, 24, "R5 idle sdo");
    check_outputs("R5");
    check("R5 ch11 on ref1", 32'(dofs_o[11*14 +: 14]), 32'h0456);

    // R9: unmapped writes
    xfer(2'd0, 6'd4,  16'h2222, 24, "R9 idle sdo");
    xfer(2'd3, 6'd7,  16'h7777, 24, "R9 idle sdo");
    xfer(2'd3, 6'd20, 16'h7777, 24, "R9 idle sdo");
    xfer(2'd0, 6'd0,  16'hFFFF, 24, "R9 idle sdo");
    xfer(2'd0, 6'd6,  16'hFFFF, 24, "R9 idle sdo");
    check_outputs("R9");

    // R8: wrong-length transfers
    xfer(2'd3, 6'd9, 16'h4444, 23, "R8");
    xfer(2'd3, 6'd9, 16'h4444, 25, "R8");
    xfer(2'd0, 6'd1, 16'h0001, 23, "R8");
    check_outputs("R8");

    // R6 / R3: readback chain; each word returns the previous request
    xfer(2'd0, 6'd5, rbq(3'd0, 6'd8),  24, "R6 idle sdo");
    xfer(2'd0, 6'd5, rbq(3'd1, 6'd19), 24, "R3 data ch0 left aligned");
    xfer(2'd0, 6'd5, rbq(3'd2, 6'd11), 24, "R6 alt type ch11");
    xfer(2'd0, 6'd5, rbq(3'd3, 6'd15), 24, "R6 offset ch3");
    xfer(2'd0, 6'd5, rbq(3'd3, 6'd16), 24, "R6 gain ch7");
    xfer(2'd0, 6'd1, 16'h0001, 24, "R6 gain ch8 reset");
    xfer(2'd0, 6'd5, rbq(3'd4, 6'd1),  24, "R7 idle sdo");
    xfer(2'd0, 6'd5, rbq(3'd4, 6'd3),  24, "R6 sf ctrl");
    xfer(2'd0, 6'd5, rbq(3'd5, 6'd8),  24, "R6 sf ofs ref1");
    xfer(2'd0, 6'd5, rbq(3'd0, 6'd30), 24, "R6 type5 zero");
    xfer(2'd0, 6'd0, 16'h0000, 24, "R6 unmapped zero");
    xfer(2'd0, 6'd0, 16'h0000, 24, "R7 zeros after use");

    // R7: a short transfer uses up a pending readback
    xfer(2'd0, 6'd5, rbq(3'd0, 6'd13), 24, "R7 idle sdo");
    xfer(2'd0, 6'd0, 16'h0000, 20, "R7");
    xfer(2'd0, 6'd0, 16'h0000, 24, "R7 pending consumed");
    check_outputs("R6 final");

    repeat (20) @(negedge clk);
    check("R7 scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule